// File: doc/BRIEF.md
# Ganged Two-Channel High-Side Switch Controller

This block is the digital control core of a two-channel high-side switch whose outputs can be tied together on the board so that the pair acts as one stronger channel. A single configuration bit selects ganged operation. A write to that bit is parked and only takes effect once both gate enables are low. The readback port reports the mode that is actually in force, not the mode that was last written.

While ganged, the channel-1 controls drive both gates. This covers the on command, the limp-home input and the PWM settings. The channel-2 controls are ignored. Protection events from either channel are merged so that both fault flags latch together and both gates drop together. The analog side (current comparators, thermal sensors, the I2T accumulator) is outside the block and arrives as digital trip flags. Fault flags are sticky until a write-1-to-clear pulse.

All outputs are registered. An input sampled at one rising edge is visible on the outputs right after that edge.

Top module: `gang_switch_ctrl`

## Requirements
- R1: A configuration write with `cfg_gang`=1 sets `gang_rb` only at a rising edge where both `gate` bits were already 0. It does so at once if they were 0 at the write edge, otherwise later. Until then `gang_rb` stays 0. After reset `gang_rb`, `gate` and all flags are 0.
- R2: A write with `cfg_gang`=0 is deferred in the same way: ganged operation stays in force until both gates are 0. A later write replaces a pending one.
- R3: When not ganged, gate k follows its own command. The command is `sw_on[k]` when PIN_CTRL=0 and `din[k]` when PIN_CTRL=1.
- R4: When ganged and `limp`=0, both gates follow the channel-1 command (bit 0 of `sw_on`, or of `din` when PIN_CTRL=1). Bit 1 has no effect.
- R5: When `limp`=1, the commands come from `limp_on` in place of `sw_on`/`din`. When ganged, both gates follow `limp_on[0]` only.
- R6: When ganged, an overcurrent trip on either channel sets both `oc_flag` bits and turns both gates off. Overcurrent trips are ignored while `inrush`=1 and `cap_reg`=1 (current-regulated charging). With `inrush`=1 and `cap_reg`=0 they act as in steady state.
- R7: When ganged, a thermal trip on either channel sets both `ot_flag` bits and turns both gates off, regardless of `inrush` and `cap_reg`.
- R8: When ganged, only `i2t_trip[0]` qualified by `i2t_en[0]` is used. It sets both `i2t_flag` bits and turns both gates off. `i2t_trip[1]` and `i2t_en[1]` have no effect.
- R9: When ganged, both gates use `pwm_en[0]` and duty slice 0 (bits PWM_W-1:0 of `pwm_duty`), with no phase offset, so both gates are identical every cycle. `pwm_shift_dis` has no effect. With PWM enabled, a gate is high in `duty` out of every 2^PWM_W cycles.
- R10: When not ganged and `pwm_shift_dis`=0, the channel-2 PWM window is offset by half a period from channel 1. With `pwm_shift_dis`=1 both windows start on the same count.
- R11: Flags are sticky. `flt_clr[k]`=1 clears all flags of channel k, and when ganged either bit clears both channels. A trip present in the same cycle wins over the clear. A gate stays off while its channel has a flag, and when ganged both gates stay off while any flag is set.
- R12: When not ganged, trips only set the flags of the channel on which they occur and only turn that gate off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_gang | input | 1 | Written value of the gang-mode bit |
| sw_on | input | 2 | Register on commands, bit k = channel k+1 |
| din | input | 2 | Direct input pins, bit k = channel k+1 |
| limp | input | 1 | Limp-home state active |
| limp_on | input | 2 | Limp-home on inputs |
| oc_trip | input | 2 | Overcurrent comparator flags |
| ot_trip | input | 2 | Thermal shutdown flags |
| i2t_trip | input | 2 | I2T accumulator trip flags |
| i2t_en | input | 2 | I2T enables |
| inrush | input | 1 | Inrush period active |
| cap_reg | input | 1 | Inrush charging mode: 1 = current regulation, 0 = none |
| pwm_en | input | 2 | PWM enables |
| pwm_duty | input | 2×PWM_W | Duty values, slice k for channel k+1 |
| pwm_shift_dis | input | 1 | Disable half-period offset of channel 2 |
| flt_clr | input | 2 | Write-1-to-clear fault strobes |
| gate | output | 2 | Gate enables |
| oc_flag | output | 2 | Sticky overcurrent flags |
| ot_flag | output | 2 | Sticky thermal flags |
| i2t_flag | output | 2 | Sticky I2T flags |
| gang_rb | output | 1 | Gang mode in force |

## Verification
The bench builds two instances with PWM_W=3, one with PIN_CTRL=0 and one with PIN_CTRL=1, so that both command sources can be checked against the same stimulus. The short 8-cycle PWM period lets one window of eight samples count the exact duty of each gate. The same window shows whether the two windows overlap, coincide or are disjoint in each mode. The deferred mode change is reached by writing while a gate is high, then dropping the command and watching the readback over the following edges.

// File: rtl/gsc_pkg.sv
package gsc_pkg;

    localparam int NCH = 2;

    typedef struct packed {
        logic [NCH-1:0] oc;
        logic [NCH-1:0] ot;
        logic [NCH-1:0] i2t;
    } flt_t;

    typedef struct packed {
        logic gang;
        logic pend;
        logic pend_val;
    } mode_st_t;

endpackage

// File: rtl/gsc_mode.sv
module gsc_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic val_i,
    input  logic off_i,
    output logic gang_o
);
    import gsc_pkg::*;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.pend     = 1'b1;
            st_d.pend_val = val_i;
        end
        if (st_d.pend && off_i) begin
            st_d.gang = st_d.pend_val;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gang_o = st_q.gang;

    // R1, R2: mode only moves at an edge where both gates were low
    a_r1_switch_only_off : assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gang != $past(st_q.gang)) |-> $past(off_i));

endmodule

// File: rtl/gsc_pwm.sv
module gsc_pwm #(
    parameter int PWM_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          gang_i,
    input  logic [gsc_pkg::NCH-1:0]            en_i,
    input  logic [gsc_pkg::NCH-1:0][PWM_W-1:0] duty_i,
    input  logic                          shift_dis_i,
    output logic [gsc_pkg::NCH-1:0]            pass_o
);
    import gsc_pkg::*;

    localparam logic [PWM_W-1:0] HALF = PWM_W'(1) << (PWM_W - 1);

    logic [PWM_W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + PWM_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic             sel_en;
        logic [PWM_W-1:0] sel_duty;
        logic [PWM_W-1:0] phase;
        logic             shifted;
        always_comb begin
            sel_en    = gang_i ? en_i[0]   : en_i[c];
            sel_duty  = gang_i ? duty_i[0] : duty_i[c];
            shifted   = (c % 2 == 1) && !gang_i && !shift_dis_i;
            phase     = cnt_q + (shifted ? HALF : '0);
            pass_o[c] = !sel_en || (phase < sel_duty);
        end
    end

    // R10: equal duties no wider than half a period never overlap when offset
    a_r10_disjoint_windows : assert property (@(posedge clk) disable iff (!rst_n)
        (!gang_i && !shift_dis_i && en_i == 2'b11 && duty_i[0] == duty_i[1]
         && duty_i[0] <= HALF) |-> !(pass_o[0] && pass_o[1]));

endmodule

// File: rtl/gsc_protect.sv
module gsc_protect (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  gang_i,
    input  logic [gsc_pkg::NCH-1:0] oc_i,
    input  logic [gsc_pkg::NCH-1:0] ot_i,
    input  logic [gsc_pkg::NCH-1:0] i2t_i,
    input  logic [gsc_pkg::NCH-1:0] i2t_en_i,
    input  logic                  inrush_i,
    input  logic                  capreg_i,
    input  logic [gsc_pkg::NCH-1:0] clr_i,
    output gsc_pkg::flt_t           flt_o,
    output logic [gsc_pkg::NCH-1:0] kill_o
);
    import gsc_pkg::*;

    flt_t           flt_d, flt_q;
    logic [NCH-1:0] oc_raw, i2t_raw, clr_eff, any_d;
    flt_t           ev;

    always_comb begin
        oc_raw  = oc_i & {NCH{!(inrush_i && capreg_i)}};
        i2t_raw = i2t_i & i2t_en_i;
        if (gang_i) begin
            ev.oc   = {NCH{|oc_raw}};
            ev.ot   = {NCH{|ot_i}};
            ev.i2t  = {NCH{i2t_raw[0]}};
            clr_eff = {NCH{|clr_i}};
        end else begin
            ev.oc   = oc_raw;
            ev.ot   = ot_i;
            ev.i2t  = i2t_raw;
            clr_eff = clr_i;
        end
        flt_d.oc  = (flt_q.oc  & ~clr_eff) | ev.oc;
        flt_d.ot  = (flt_q.ot  & ~clr_eff) | ev.ot;
        flt_d.i2t = (flt_q.i2t & ~clr_eff) | ev.i2t;
        any_d     = flt_d.oc | flt_d.ot | flt_d.i2t;
        kill_o    = gang_i ? {NCH{|any_d}} : any_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flt_q <= '0;
        else        flt_q <= flt_d;
    end

    assign flt_o = flt_q;

    // R6: ganged overcurrent outside regulated inrush flags both channels
    a_r6_oc_both : assert property (@(posedge clk) disable iff (!rst_n)
        (gang_i && !(inrush_i && capreg_i) && (oc_i != '0)) |=> (flt_q.oc == 2'b11));

    // R7: ganged thermal trip flags both channels in every phase
    a_r7_ot_both : assert property (@(posedge clk) disable iff (!rst_n)
        (gang_i && (ot_i != '0)) |=> (flt_q.ot == 2'b11));

    // R8: channel-2 I2T input cannot raise a flag when ganged
    a_r8_i2t_ch2_ignored : assert property (@(posedge clk) disable iff (!rst_n)
        (gang_i && !i2t_i[0] && flt_q.i2t == 2'b00) |=> (flt_q.i2t == 2'b00));

    // R11: a flag holds until its clear strobe
    a_r11_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q.oc[0] && !clr_i[0] && !(gang_i && clr_i[1])) |=> flt_q.oc[0]);

endmodule

// File: rtl/gang_switch_ctrl.sv
module gang_switch_ctrl #(
    parameter int PWM_W    = 8,
    parameter bit PIN_CTRL = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic                  cfg_gang,
    input  logic [1:0]            sw_on,
    input  logic [1:0]            din,
    input  logic                  limp,
    input  logic [1:0]            limp_on,
    input  logic [1:0]            oc_trip,
    input  logic [1:0]            ot_trip,
    input  logic [1:0]            i2t_trip,
    input  logic [1:0]            i2t_en,
    input  logic                  inrush,
    input  logic                  cap_reg,
    input  logic [1:0]            pwm_en,
    input  logic [1:0][PWM_W-1:0] pwm_duty,
    input  logic                  pwm_shift_dis,
    input  logic [1:0]            flt_clr,
    output logic [1:0]            gate,
    output logic [1:0]            oc_flag,
    output logic [1:0]            ot_flag,
    output logic [1:0]            i2t_flag,
    output logic                  gang_rb
);
    import gsc_pkg::*;

    typedef struct packed {
        logic [NCH-1:0] gate;
    } top_st_t;

    top_st_t        st_d, st_q;
    logic           gang;
    logic [NCH-1:0] pass, kill, src, cmd;
    flt_t           flt;

    gsc_mode i_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (cfg_wr),
        .val_i  (cfg_gang),
        .off_i  (st_q.gate == '0),
        .gang_o (gang)
    );

    gsc_pwm #(.PWM_W(PWM_W)) i_pwm (
        .clk         (clk),
        .rst_n       (rst_n),
        .gang_i      (gang),
        .en_i        (pwm_en),
        .duty_i      (pwm_duty),
        .shift_dis_i (pwm_shift_dis),
        .pass_o      (pass)
    );

    gsc_protect i_prot (
        .clk      (clk),
        .rst_n    (rst_n),
        .gang_i   (gang),
        .oc_i     (oc_trip),
        .ot_i     (ot_trip),
        .i2t_i    (i2t_trip),
        .i2t_en_i (i2t_en),
        .inrush_i (inrush),
        .capreg_i (cap_reg),
        .clr_i    (flt_clr),
        .flt_o    (flt),
        .kill_o   (kill)
    );

    always_comb begin
        st_d = st_q;
        if (limp)          src = limp_on;
        else if (PIN_CTRL) src = din;
        else               src = sw_on;
        cmd       = gang ? {NCH{src[0]}} : src;
        st_d.gate = cmd & pass & ~kill;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gate     = st_q.gate;
    assign oc_flag  = flt.oc;
    assign ot_flag  = flt.ot;
    assign i2t_flag = flt.i2t;
    assign gang_rb  = gang;

    // R4, R9: while ganged both gates are twins
    a_r4_gang_twins : assert property (@(posedge clk) disable iff (!rst_n)
        $past(gang) |-> (st_q.gate[0] == st_q.gate[1]));

    // R11: a flagged channel never drives its gate
    a_r11_flag_blocks_ch1 : assert property (@(posedge clk) disable iff (!rst_n)
        (flt.oc[0] || flt.ot[0] || flt.i2t[0]) |-> !st_q.gate[0]);
    a_r11_flag_blocks_ch2 : assert property (@(posedge clk) disable iff (!rst_n)
        (flt.oc[1] || flt.ot[1] || flt.i2t[1]) |-> !st_q.gate[1]);

endmodule

// File: tb/test_gang_switch_ctrl.sv
`timescale 1ns/1ps
module test_gang_switch_ctrl;

    localparam int W = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_wr = 0, cfg_gang = 0, limp = 0, inrush = 0, cap_reg = 0, shift_dis = 0;
    logic [1:0]      sw_on = 0, din = 0, limp_on = 0, oc = 0, ot = 0, i2t = 0, i2t_en = 0;
    logic [1:0]      pwm_en = 0, clr = 0;
    logic [1:0][W-1:0] duty = '0;
    logic [1:0]      gate, oc_f, ot_f, i2t_f, gate_p, oc_p, ot_p, i2t_p;
    logic            gang_rb, gang_p;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    gang_switch_ctrl #(.PWM_W(W), .PIN_CTRL(1'b0)) i_gang_switch_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_gang(cfg_gang),
        .sw_on(sw_on), .din(din), .limp(limp), .limp_on(limp_on),
        .oc_trip(oc), .ot_trip(ot), .i2t_trip(i2t), .i2t_en(i2t_en),
        .inrush(inrush), .cap_reg(cap_reg), .pwm_en(pwm_en), .pwm_duty(duty),
        .pwm_shift_dis(shift_dis), .flt_clr(clr), .gate(gate), .oc_flag(oc_f),
        .ot_flag(ot_f), .i2t_flag(i2t_f), .gang_rb(gang_rb));

    gang_switch_ctrl #(.PWM_W(W), .PIN_CTRL(1'b1)) i_gang_switch_ctrl_pin (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_gang(cfg_gang),
        .sw_on(sw_on), .din(din), .limp(limp), .limp_on(limp_on),
        .oc_trip(oc), .ot_trip(ot), .i2t_trip(i2t), .i2t_en(i2t_en),
        .inrush(inrush), .cap_reg(cap_reg), .pwm_en(pwm_en), .pwm_duty(duty),
        .pwm_shift_dis(shift_dis), .flt_clr(clr), .gate(gate_p), .oc_flag(oc_p),
        .ot_flag(ot_p), .i2t_flag(i2t_p), .gang_rb(gang_p));

    typedef struct packed {
        logic [7:0] tag;
        logic       wr, val;
        logic [1:0] on;
        logic       lmp;
        logic [1:0] lin, oc, ot, i2t, ien;
        logic       inr, creg;
        logic [1:0] clr, eg, eoc, eot, ei2t;
        logic       egang;
    } vec_t;

    localparam int NV = 32;
    // fields: tag wr val on limp lin oc ot i2t ien inr creg clr | gate oc ot i2t gang
    localparam vec_t VECS [NV] = '{
        '{3, 0,0,2'b01,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b01,2'b00,2'b00,2'b00,0}, // R3
        '{3, 0,0,2'b10,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b10,2'b00,2'b00,2'b00,0}, // R3
        '{1, 1,1,2'b10,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b10,2'b00,2'b00,2'b00,0}, // R1 write while on
        '{1, 0,0,2'b00,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b00,2'b00,2'b00,2'b00,0}, // R1 still pending
        '{1, 0,0,2'b00,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b00,2'b00,2'b00,2'b00,1}, // R1 applied
        '{4, 0,0,2'b10,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b00,2'b00,2'b00,2'b00,1}, // R4 ch2 ignored
        '{4, 0,0,2'b01,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b11,2'b00,2'b00,2'b00,1}, // R4
        '{6, 0,0,2'b01,0,2'b00,2'b10,2'b00,2'b00,2'b00,0,0,2'b00, 2'b00,2'b11,2'b00,2'b00,1}, // R6 ch2 oc
        '{11,0,0,2'b01,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b00,2'b11,2'b00,2'b00,1}, // R11 sticky
        '{11,0,0,2'b01,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b10, 2'b11,2'b00,2'b00,2'b00,1}, // R11 clr bit1
        '{6, 0,0,2'b01,0,2'b00,2'b11,2'b00,2'b00,2'b00,1,1,2'b00, 2'b11,2'b00,2'b00,2'b00,1}, // R6 regulated
        '{6, 0,0,2'b01,0,2'b00,2'b01,2'b00,2'b00,2'b00,1,0,2'b00, 2'b00,2'b11,2'b00,2'b00,1}, // R6 no-charge
        '{11,0,0,2'b01,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b01, 2'b11,2'b00,2'b00,2'b00,1}, // R11
        '{7, 0,0,2'b01,0,2'b00,2'b00,2'b10,2'b00,2'b00,1,1,2'b00, 2'b00,2'b00,2'b11,2'b00,1}, // R7
        '{11,0,0,2'b01,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b11, 2'b11,2'b00,2'b00,2'b00,1}, // R11
        '{8, 0,0,2'b01,0,2'b00,2'b00,2'b00,2'b10,2'b11,0,0,2'b00, 2'b11,2'b00,2'b00,2'b00,1}, // R8 ch2 trip
        '{8, 0,0,2'b01,0,2'b00,2'b00,2'b00,2'b01,2'b10,0,0,2'b00, 2'b11,2'b00,2'b00,2'b00,1}, // R8 ch1 disabled
        '{8, 0,0,2'b01,0,2'b00,2'b00,2'b00,2'b01,2'b01,0,0,2'b00, 2'b00,2'b00,2'b00,2'b11,1}, // R8 ch1 trip
        '{11,0,0,2'b01,0,2'b00,2'b00,2'b00,2'b01,2'b01,0,0,2'b01, 2'b00,2'b00,2'b00,2'b11,1}, // R11 set wins
        '{11,0,0,2'b01,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b01, 2'b11,2'b00,2'b00,2'b00,1}, // R11
        '{2, 1,0,2'b01,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b11,2'b00,2'b00,2'b00,1}, // R2 write while on
        '{2, 0,0,2'b00,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b00,2'b00,2'b00,2'b00,1}, // R2 pending
        '{2, 0,0,2'b00,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b00,2'b00,2'b00,2'b00,0}, // R2 applied
        '{12,0,0,2'b11,0,2'b00,2'b01,2'b00,2'b00,2'b00,0,0,2'b00, 2'b10,2'b01,2'b00,2'b00,0}, // R12
        '{12,0,0,2'b11,0,2'b00,2'b00,2'b10,2'b00,2'b00,0,0,2'b00, 2'b00,2'b01,2'b10,2'b00,0}, // R12
        '{11,0,0,2'b11,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b11, 2'b11,2'b00,2'b00,2'b00,0}, // R11
        '{5, 0,0,2'b11,1,2'b10,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b10,2'b00,2'b00,2'b00,0}, // R5
        '{5, 0,0,2'b11,1,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b00,2'b00,2'b00,2'b00,0}, // R5
        '{5, 1,1,2'b11,1,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b00,2'b00,2'b00,2'b00,1}, // R5 R1
        '{5, 0,0,2'b11,1,2'b01,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b11,2'b00,2'b00,2'b00,1}, // R5
        '{5, 0,0,2'b11,1,2'b10,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b00,2'b00,2'b00,2'b00,1}, // R5
        '{4, 0,0,2'b00,0,2'b00,2'b00,2'b00,2'b00,2'b00,0,0,2'b00, 2'b00,2'b00,2'b00,2'b00,1}  // R4
    };

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic pulse_wr(input logic v);
        cfg_wr = 1'b1; cfg_gang = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic count8(output int c0, output int c1, output int both, output int diff);
        c0 = 0; c1 = 0; both = 0; diff = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            c0   += int'(gate[0]);
            c1   += int'(gate[1]);
            both += int'(gate[0] & gate[1]);
            diff += int'(gate[0] ^ gate[1]);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int c0, c1, both, diff;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset gate", 8'(gate), 8'h0);
        chk("R1 reset flags", 8'({oc_f, ot_f, i2t_f}), 8'h0);
        chk("R1 reset gang", 8'(gang_rb), 8'h0);

        for (int i = 0; i < NV; i++) begin
            cfg_wr = VECS[i].wr; cfg_gang = VECS[i].val; sw_on = VECS[i].on;
            limp = VECS[i].lmp; limp_on = VECS[i].lin; oc = VECS[i].oc; ot = VECS[i].ot;
            i2t = VECS[i].i2t; i2t_en = VECS[i].ien; inrush = VECS[i].inr;
            cap_reg = VECS[i].creg; clr = VECS[i].clr;
            @(negedge clk);
            chk($sformatf("R%0d vec %0d gate", VECS[i].tag, i), 8'(gate), 8'(VECS[i].eg));
            chk($sformatf("R%0d vec %0d flags", VECS[i].tag, i),
                8'({oc_f, ot_f, i2t_f}), 8'({VECS[i].eoc, VECS[i].eot, VECS[i].ei2t}));
            chk($sformatf("R%0d vec %0d gang", VECS[i].tag, i), 8'(gang_rb), 8'(VECS[i].egang));
        end
        cfg_wr = 0; clr = 0;

        // R4 pin variant: ganged, din bit 1 ignored
        din = 2'b10;
        @(negedge clk);
        chk("R4 pin gang ch2 ignored", 8'(gate_p), 8'h0);
        chk("R4 pin gang readback", 8'(gang_p), 8'h1);
        din = 2'b01;
        @(negedge clk);
        chk("R4 pin gang follows din0", 8'(gate_p), 8'h3);
        chk("R3 reg variant ignores din", 8'(gate), 8'h0);
        din = 2'b00;
        pulse_wr(1'b0);
        @(negedge clk);
        @(negedge clk);
        chk("R2 pin gang cleared", 8'(gang_p), 8'h0);
        din = 2'b10;
        @(negedge clk);
        chk("R3 pin independent", 8'(gate_p), 8'h2);
        din = 2'b00;

        // R10 independent PWM offset
        chk("R10 gang off", 8'(gang_rb), 8'h0);
        sw_on = 2'b11; pwm_en = 2'b11; duty[0] = 3'd2; duty[1] = 3'd2; shift_dis = 0;
        repeat (2) @(negedge clk);
        count8(c0, c1, both, diff);
        chk("R10 ch1 duty", 8'(c0), 8'd2);
        chk("R10 ch2 duty", 8'(c1), 8'd2);
        chk("R10 offset windows disjoint", 8'(both), 8'd0);
        shift_dis = 1;
        repeat (2) @(negedge clk);
        count8(c0, c1, both, diff);
        chk("R10 shift disabled windows aligned", 8'(both), 8'd2);

        // R9 ganged PWM uses channel 1 settings only
        sw_on = 2'b00; pwm_en = 2'b00; shift_dis = 0;
        @(negedge clk);
        pulse_wr(1'b1);
        @(negedge clk);
        chk("R9 gang entered", 8'(gang_rb), 8'h1);
        sw_on = 2'b01; pwm_en = 2'b01; duty[0] = 3'd3; duty[1] = 3'd6;
        repeat (2) @(negedge clk);
        count8(c0, c1, both, diff);
        chk("R9 ch1 duty", 8'(c0), 8'd3);
        chk("R9 ch2 uses ch1 duty", 8'(c1), 8'd3);
        chk("R9 gates identical", 8'(diff), 8'd0);
        pwm_en = 2'b10;
        repeat (2) @(negedge clk);
        count8(c0, c1, both, diff);
        chk("R9 ch2 enable ignored", 8'(both), 8'd8);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule